// File: doc/BRIEF.md
# Knob Panel Host Command Parser

This block interprets the byte stream that a host sends over an asynchronous serial link to an eight-knob input panel. The bytes arrive already deserialised, one per cycle, qualified by a valid flag. Single-byte commands are recognised directly: one requests a revision report, one requests a self-test, and one places the panel in loopback mode.

An escape byte opens a multi-byte command. The byte after the escape is a control byte, and fixed bits in it decide the command type:
- a per-knob delta threshold, carrying a 15-bit value sent low byte first;
- a report-rate code;
- an eight-character label for one knob.

Each completed command is issued as a one-cycle strobe. Its payload is valid on the ports while the strobe is high.

A control byte that matches no pattern aborts the sequence and raises an error strobe. Label characters outside the printable range the panel can show are replaced by a space. A zero threshold is raised to one. The loopback flag is sticky and is cleared by any received byte other than the revision query.

Top module: `knob_cmd_parser`

## Requirements
- R1: While `rst_n` is low, every strobe and `loop_mode` are 0 and the parser is idle.
- R2: `loop_mode` is set by a pulse on `selftest_pass` or by byte 0x04 received while idle. Byte 0x05 leaves it unchanged. Any other received byte clears it, including a 0x04 that arrives as data inside a multi-byte command. A clearing byte wins over a `selftest_pass` pulse in the same cycle.
- R3: While idle, byte 0x05 pulses `rev_req` and byte 0x13 pulses `test_req`.
- R4: While idle, byte 0x16 makes the next byte a control byte. Any other idle byte raises no strobe, and cycles with `rx_valid` low have no effect.
- R5: A control byte with bit 7 = 1 and bit 5 = 0 selects a threshold command. The knob is control bits 2:0, sent on `cmd_enc`. Two more bytes follow, low then high, and `thr_value` = {high[6:0], low}.
- R6: A threshold value of zero is issued as 1.
- R7: A control byte with bits 7 and 5 both 1 selects a rate command. The first byte after it is ignored, and the second byte appears on `rate_code`.
- R8: A control byte with bits 7 and 3 both 0 selects a label command. The knob is control bits 2:0. The i-th of the eight following bytes appears on `label_text[8i+7:8i]`.
- R9: A label character below 0x20 or above 0x5F is issued as 0x20.
- R10: A control byte with bit 7 = 0 and bit 3 = 1 pulses `err_stb` and returns the parser to idle, so the following byte is read as a new command.
- R11: Each strobe rises in the cycle after the clock edge that takes the completing byte, lasts one cycle, and at most one strobe is high in any cycle.
- R12: Bytes inside a multi-byte command are data only. Values such as 0x05, 0x13 or 0x16 raise no command strobe there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | `rx_data` holds a received byte this cycle |
| rx_data | input | 8 | Received byte |
| selftest_pass | input | 1 | Pulse: power-up self-test succeeded, enter loopback |
| loop_mode | output | 1 | Loopback mode flag |
| rev_req | output | 1 | Revision report request strobe |
| test_req | output | 1 | Self-test request strobe |
| thr_stb | output | 1 | Threshold command strobe |
| rate_stb | output | 1 | Rate command strobe |
| label_stb | output | 1 | Label command strobe |
| err_stb | output | 1 | Malformed control byte strobe |
| cmd_enc | output | ENC_W | Knob index of threshold or label command |
| thr_value | output | 15 | Threshold value, never zero |
| rate_code | output | 8 | Rate code |
| label_text | output | 8*LABEL_LEN | Label characters, first received in bits 7:0 |

## Verification
The assertions watch, on every cycle, the properties that hold for any byte sequence:
- at most one strobe is high;
- a threshold strobe never carries zero;
- every issued label character is in range;
- the loopback flag clears or holds according to the byte just taken;
- bytes inside a command body never pulse a single-byte request.

Only the bench scenarios can show that the right payload values appear for each control pattern:
- byte order;
- bit 7 of the threshold high byte being dropped;
- the reserved rate byte being skipped;
- recovery after an error strobe;
- back-to-back commands with no idle cycles between them.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int BYTE_W = 8;
  localparam int THR_W  = 2 * BYTE_W - 1;

  localparam logic [BYTE_W-1:0] CODE_LOOP = 8'h04;
  localparam logic [BYTE_W-1:0] CODE_REV  = 8'h05;
  localparam logic [BYTE_W-1:0] CODE_TEST = 8'h13;
  localparam logic [BYTE_W-1:0] CODE_ESC  = 8'h16;

  localparam logic [BYTE_W-1:0] CHAR_LO   = 8'h20;
  localparam logic [BYTE_W-1:0] CHAR_HI   = 8'h5F;
  localparam logic [BYTE_W-1:0] CHAR_FILL = 8'h20;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_CTRL = 2'd1,
    PS_BODY = 2'd2
  } parse_st_t;

  typedef enum logic [1:0] {
    CK_THR   = 2'd0,
    CK_RATE  = 2'd1,
    CK_LABEL = 2'd2,
    CK_BAD   = 2'd3
  } cmd_kind_t;
endpackage

// File: rtl/kp_ctrl_decode.sv
module kp_ctrl_decode
  import kp_pkg::*;
#(
  parameter int ENC_W = 3
) (
  input  logic             sel_hi,
  input  logic             rate_bit,
  input  logic             bad_bit,
  input  logic [ENC_W-1:0] enc_field,
  output cmd_kind_t        kind_o,
  output logic [ENC_W-1:0] enc_o
);
  always_comb begin
    if (sel_hi) begin
      kind_o = rate_bit ? CK_RATE : CK_THR;
    end else begin
      kind_o = bad_bit ? CK_BAD : CK_LABEL;
    end
    enc_o = enc_field;
  end
endmodule

// File: rtl/kp_char_clean.sv
module kp_char_clean
  import kp_pkg::*;
(
  input  logic [BYTE_W-1:0] raw_i,
  output logic [BYTE_W-1:0] clean_o
);
  always_comb begin
    if (raw_i < CHAR_LO || raw_i > CHAR_HI) begin
      clean_o = CHAR_FILL;
    end else begin
      clean_o = raw_i;
    end
  end
endmodule

// File: rtl/kp_body_buf.sv
module kp_body_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [W-1:0]       wr_data,
  output logic [DEPTH*W-1:0] data_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_en;

    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign data_o[g*W +: W] = slot_q;
  end
endmodule

// File: rtl/knob_cmd_parser.sv
module knob_cmd_parser
  import kp_pkg::*;
#(
  parameter int LABEL_LEN = 8,
  parameter int ENC_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_data,
  input  logic                        selftest_pass,
  output logic                        loop_mode,
  output logic                        rev_req,
  output logic                        test_req,
  output logic                        thr_stb,
  output logic                        rate_stb,
  output logic                        label_stb,
  output logic                        err_stb,
  output logic [ENC_W-1:0]            cmd_enc,
  output logic [14:0]                 thr_value,
  output logic [7:0]                  rate_code,
  output logic [LABEL_LEN*8-1:0]      label_text
);
  localparam int IDX_W   = (LABEL_LEN > 2) ? $clog2(LABEL_LEN) : 1;
  localparam int BUF_W   = LABEL_LEN * BYTE_W;

  parse_st_t         st_q, st_d;
  cmd_kind_t         kind_q, kind_d, dec_kind;
  logic [ENC_W-1:0]  enc_q, enc_d, dec_enc;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic              loop_q, loop_d;
  logic              rev_q, rev_d, test_q, test_d;
  logic              thr_q, thr_d, rate_q, rate_d;
  logic              lab_q, lab_d, err_q, err_d;
  logic              wr_en;
  logic              take_loop, drop_loop;
  logic [BUF_W-1:0]  buf_flat;
  logic [THR_W-1:0]  thr_raw;

  kp_ctrl_decode #(.ENC_W(ENC_W)) u_decode (
    .sel_hi    (rx_data[7]),
    .rate_bit  (rx_data[5]),
    .bad_bit   (rx_data[3]),
    .enc_field (rx_data[ENC_W-1:0]),
    .kind_o    (dec_kind),
    .enc_o     (dec_enc)
  );

  kp_body_buf #(.DEPTH(LABEL_LEN), .W(BYTE_W), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx_q),
    .wr_data (rx_data),
    .data_o  (buf_flat)
  );

  assign last_idx  = (kind_q == CK_LABEL) ? IDX_W'(LABEL_LEN - 1) : IDX_W'(1);
  assign take_loop = rx_valid && (st_q == PS_IDLE) && (rx_data == CODE_LOOP);
  assign drop_loop = rx_valid && (rx_data != CODE_REV) && !take_loop;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    enc_d  = enc_q;
    idx_d  = idx_q;
    wr_en  = 1'b0;
    rev_d  = 1'b0;
    test_d = 1'b0;
    thr_d  = 1'b0;
    rate_d = 1'b0;
    lab_d  = 1'b0;
    err_d  = 1'b0;
    if (rx_valid) begin
      unique case (st_q)
        PS_IDLE: begin
          if (rx_data == CODE_REV) begin
            rev_d = 1'b1;
          end else if (rx_data == CODE_TEST) begin
            test_d = 1'b1;
          end else if (rx_data == CODE_ESC) begin
            st_d = PS_CTRL;
          end
        end
        PS_CTRL: begin
          if (dec_kind == CK_BAD) begin
            err_d = 1'b1;
            st_d  = PS_IDLE;
          end else begin
            kind_d = dec_kind;
            enc_d  = dec_enc;
            idx_d  = '0;
            st_d   = PS_BODY;
          end
        end
        PS_BODY: begin
          wr_en = 1'b1;
          if (idx_q == last_idx) begin
            st_d = PS_IDLE;
            unique case (kind_q)
              CK_THR:   thr_d  = 1'b1;
              CK_RATE:  rate_d = 1'b1;
              CK_LABEL: lab_d  = 1'b1;
              default:  err_d  = 1'b1;
            endcase
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
    if (drop_loop) begin
      loop_d = 1'b0;
    end else if (take_loop || selftest_pass) begin
      loop_d = 1'b1;
    end else begin
      loop_d = loop_q;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      kind_q <= CK_THR;
      enc_q  <= '0;
      idx_q  <= '0;
      loop_q <= 1'b0;
      rev_q  <= 1'b0;
      test_q <= 1'b0;
      thr_q  <= 1'b0;
      rate_q <= 1'b0;
      lab_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      enc_q  <= enc_d;
      idx_q  <= idx_d;
      loop_q <= loop_d;
      rev_q  <= rev_d;
      test_q <= test_d;
      thr_q  <= thr_d;
      rate_q <= rate_d;
      lab_q  <= lab_d;
      err_q  <= err_d;
    end
  end

  // Payload views of the body buffer
  assign thr_raw   = {buf_flat[2*BYTE_W-2:BYTE_W], buf_flat[BYTE_W-1:0]};
  assign thr_value = (thr_raw == '0) ? THR_W'(1) : thr_raw;
  assign rate_code = buf_flat[2*BYTE_W-1:BYTE_W];

  for (genvar g = 0; g < LABEL_LEN; g++) begin : g_char
    kp_char_clean u_clean (
      .raw_i   (buf_flat[g*BYTE_W +: BYTE_W]),
      .clean_o (label_text[g*BYTE_W +: BYTE_W])
    );

    AST_LABEL_CHAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      label_stb |-> (label_text[g*BYTE_W +: BYTE_W] >= CHAR_LO &&
                     label_text[g*BYTE_W +: BYTE_W] <= CHAR_HI)); // R9
  end

  assign loop_mode = loop_q;
  assign rev_req   = rev_q;
  assign test_req  = test_q;
  assign thr_stb   = thr_q;
  assign rate_stb  = rate_q;
  assign label_stb = lab_q;
  assign err_stb   = err_q;
  assign cmd_enc   = enc_q;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb})); // R11

  AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    thr_stb |-> (thr_value != '0)); // R6

  AST_LOOP_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_data != CODE_REV && rx_data != CODE_LOOP) |=> !loop_mode); // R2

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_data == CODE_REV && !selftest_pass) |=> (loop_mode == $past(loop_mode))); // R2

  AST_BODY_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && st_q == PS_BODY) |=> (!rev_req && !test_req)); // R12

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> (st_q == PS_IDLE)); // R10
endmodule

// File: tb/tb_knob_cmd_parser.sv
`timescale 1ns/1ps
module tb_knob_cmd_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        selftest_pass;
  logic        loop_mode, rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb;
  logic [2:0]  cmd_enc;
  logic [14:0] thr_value;
  logic [7:0]  rate_code;
  logic [63:0] label_text;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit chk_en = 1'b0;

  always #5 clk = ~clk;

  knob_cmd_parser dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .selftest_pass(selftest_pass), .loop_mode(loop_mode), .rev_req(rev_req),
    .test_req(test_req), .thr_stb(thr_stb), .rate_stb(rate_stb),
    .label_stb(label_stb), .err_stb(err_stb), .cmd_enc(cmd_enc),
    .thr_value(thr_value), .rate_code(rate_code), .label_text(label_text)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_loop;
  int          m_ph;
  logic [7:0]  m_ctrl;
  int          m_need;
  logic [7:0]  m_q[$];
  bit          e_rev, e_test, e_thr, e_rate, e_lab, e_err;
  logic [2:0]  e_enc;
  logic [14:0] e_thv;
  logic [7:0]  e_rc;
  logic [63:0] e_lab_txt;

  always @(posedge clk) begin
    logic [7:0] b;
    bit clr, set;
    e_rev = 0; e_test = 0; e_thr = 0; e_rate = 0; e_lab = 0; e_err = 0;
    if (!rst_n) begin
      m_loop = 0; m_ph = 0; m_q.delete();
    end else begin
      clr = 0; set = 0;
      if (rx_valid) begin
        b   = rx_data;
        set = (m_ph == 0) && (b == 8'h04);
        clr = (b != 8'h05) && !set;
        if (m_ph == 0) begin
          if (b == 8'h05) e_rev = 1;
          else if (b == 8'h13) e_test = 1;
          else if (b == 8'h16) m_ph = 1;
        end else if (m_ph == 1) begin
          if (!b[7] && b[3]) begin
            e_err = 1; m_ph = 0;
          end else begin
            m_ctrl = b; m_q.delete(); m_ph = 2;
            m_need = b[7] ? 2 : 8;
          end
        end else begin
          m_q.push_back(b);
          if (m_q.size() == m_need) begin
            m_ph = 0;
            if (m_ctrl[7] && !m_ctrl[5]) begin
              e_thr = 1;
              e_enc = m_ctrl[2:0];
              e_thv = {m_q[1][6:0], m_q[0]};
              if (e_thv == 0) e_thv = 1;
            end else if (m_ctrl[7]) begin
              e_rate = 1;
              e_rc   = m_q[1];
            end else begin
              e_lab = 1;
              e_enc = m_ctrl[2:0];
              for (int i = 0; i < 8; i++) begin
                logic [7:0] c;
                c = m_q[i];
                if (c < 8'h20 || c > 8'h5F) c = 8'h20;
                e_lab_txt[i*8 +: 8] = c;
              end
            end
          end
        end
      end
      if (clr) m_loop = 0;
      else if (set || selftest_pass) m_loop = 1;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(loop_mode === m_loop, "R2 loop_mode", 64'(loop_mode), 64'(m_loop));
      check(rev_req === e_rev, "R3 rev_req", 64'(rev_req), 64'(e_rev));
      check(test_req === e_test, "R3 test_req", 64'(test_req), 64'(e_test));
      check(thr_stb === e_thr, "R5 thr_stb", 64'(thr_stb), 64'(e_thr));
      check(rate_stb === e_rate, "R7 rate_stb", 64'(rate_stb), 64'(e_rate));
      check(label_stb === e_lab, "R8 label_stb", 64'(label_stb), 64'(e_lab));
      check(err_stb === e_err, "R10 err_stb", 64'(err_stb), 64'(e_err));
      check($countones({rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb}) <= 1,
            "R11 single strobe", 64'({rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb}), 64'd0);
      if (e_thr) begin
        check(thr_value === e_thv, "R5 thr_value", 64'(thr_value), 64'(e_thv));
        check(cmd_enc === e_enc, "R5 cmd_enc", 64'(cmd_enc), 64'(e_enc));
      end
      if (e_rate) check(rate_code === e_rc, "R7 rate_code", 64'(rate_code), 64'(e_rc));
      if (e_lab) begin
        check(label_text === e_lab_txt, "R8 label_text", label_text, e_lab_txt);
        check(cmd_enc === e_enc, "R8 cmd_enc", 64'(cmd_enc), 64'(e_enc));
      end
    end
  end

  task automatic burst(input logic [7:0] bs[10], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = bs[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'hEE;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; selftest_pass = 1'b0;
    repeat (3) @(negedge clk);
    check({loop_mode, rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb} === 7'b0,
          "R1 reset outputs",
          64'({loop_mode, rev_req, test_req, thr_stb, rate_stb, label_stb, err_stb}), 64'd0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    idle(2);

    // loopback entry and exit
    selftest_pass = 1'b1; @(negedge clk); selftest_pass = 1'b0;
    check(loop_mode === 1'b1, "R2 enter on self-test pass", 64'(loop_mode), 64'd1);
    burst('{8'h05,0,0,0,0,0,0,0,0,0}, 1);
    check(loop_mode === 1'b1, "R2 revision query keeps loopback", 64'(loop_mode), 64'd1);
    idle(1);
    burst('{8'h41,0,0,0,0,0,0,0,0,0}, 1);
    check(loop_mode === 1'b0, "R2 other byte leaves loopback", 64'(loop_mode), 64'd0);
    check(rev_req === 1'b0 && err_stb === 1'b0, "R4 idle byte raises nothing", 64'(rev_req), 64'd0);
    burst('{8'h04,0,0,0,0,0,0,0,0,0}, 1);
    check(loop_mode === 1'b1, "R2 byte 0x04 enters loopback", 64'(loop_mode), 64'd1);

    // garbage with valid low
    rx_data = 8'h13; idle(3);
    check(test_req === 1'b0 && loop_mode === 1'b1, "R4 invalid cycles ignored",
          64'({test_req, loop_mode}), 64'h1);

    burst('{8'h13,0,0,0,0,0,0,0,0,0}, 1);
    check(test_req === 1'b1, "R3 self-test request", 64'(test_req), 64'd1);

    // threshold
    burst('{8'h16,8'h83,8'h34,8'h12,0,0,0,0,0,0}, 4);
    check(thr_value === 15'h1234 && cmd_enc === 3'd3, "R5 threshold low-first",
          64'({cmd_enc, thr_value}), 64'({3'd3, 15'h1234}));
    burst('{8'h16,8'h87,8'hFF,8'hFF,0,0,0,0,0,0}, 4);
    check(thr_value === 15'h7FFF, "R5 high bit 7 dropped", 64'(thr_value), 64'h7FFF);
    burst('{8'h16,8'h81,8'h00,8'h00,0,0,0,0,0,0}, 4);
    check(thr_value === 15'h0001, "R6 zero clamp", 64'(thr_value), 64'd1);
    burst('{8'h16,8'h80,8'h00,8'h80,0,0,0,0,0,0}, 4);
    check(thr_value === 15'h0001, "R6 zero clamp with bit 7 set", 64'(thr_value), 64'd1);

    // rate
    burst('{8'h16,8'hA0,8'h99,8'h1E,0,0,0,0,0,0}, 4);
    check(rate_stb === 1'b1 && rate_code === 8'h1E, "R7 rate code", 64'(rate_code), 64'h1E);

    // labels
    burst('{8'h16,8'h05,8'h48,8'h45,8'h4C,8'h4C,8'h4F,8'h2D,8'h31,8'h32}, 10);
    check(label_text === 64'h32312D4F4C4C4548 && cmd_enc === 3'd5, "R8 label text",
          label_text, 64'h32312D4F4C4C4548);
    burst('{8'h16,8'h47,8'h7A,8'h10,8'h60,8'h5F,8'h20,8'h1F,8'h41,8'hFF}, 10);
    check(label_text === 64'h20412020_5F202020, "R9 out-of-range replaced",
          label_text, 64'h20412020_5F202020);

    // bad control byte, then immediate new command
    burst('{8'h16,8'h08,8'h05,0,0,0,0,0,0,0}, 3);
    check(rev_req === 1'b1, "R10 recovery after error", 64'(rev_req), 64'd1);

    // command bytes as data
    burst('{8'h16,8'h82,8'h05,8'h13,0,0,0,0,0,0}, 4);
    check(thr_value === 15'h1305 && cmd_enc === 3'd2, "R12 data bytes not commands",
          64'(thr_value), 64'h1305);

    // loopback: clearing byte wins over self-test pulse; 0x04 as data clears
    burst('{8'h04,0,0,0,0,0,0,0,0,0}, 1);
    @(negedge clk); selftest_pass = 1'b1; rx_valid = 1'b1; rx_data = 8'h41;
    @(negedge clk); selftest_pass = 1'b0; rx_valid = 1'b0;
    check(loop_mode === 1'b0, "R2 clear beats self-test pulse", 64'(loop_mode), 64'd0);
    burst('{8'h04,8'h16,0,0,0,0,0,0,0,0}, 2);
    burst('{8'h81,8'h04,8'h00,0,0,0,0,0,0,0}, 3);
    check(loop_mode === 1'b0 && thr_value === 15'h0004, "R2 data 0x04 clears loopback",
          64'({loop_mode, thr_value}), 64'h4);

    // back-to-back commands (model compares every cycle)
    burst('{8'h13,8'h16,8'hA3,8'h00,8'h05,8'h05,8'h16,8'h8F,8'h01,8'h00}, 10);
    check(thr_value === 15'h0001 && cmd_enc === 3'd7, "R11 back-to-back commands",
          64'({cmd_enc, thr_value}), 64'({3'd7, 15'h1}));

    idle(5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule